// File: doc/BRIEF.md
# Mode Strap and External Interrupt Front-End

This block lets four shared active-low input pins do two jobs. While the chip is held in reset the pins serve as boot-mode straps; the level they carry when reset is let go is frozen into a 4-bit operating-mode register that stays put until the next reset. From then on each pin is an external interrupt request. Software-side logic gives every line its own mask bit and its own trigger choice: level-sensitive, where the request simply mirrors a low pin, or falling-edge, where a 1-to-0 transition sets a sticky pending flag that is cleared by a per-line acknowledge.

Every pin passes through a two-flop synchronizer on the core clock before any logic sees it. Detection is held off during reset and for the first cycle after it, so strap levels cannot be mistaken for interrupts. Line A also produces a wake request that ends a stop state, independent of its mask.

Top module: `sis_strap_irq_top`

## Requirements
- R1: Each pin reaches the logic through two core-clock flops: a pin falling just before rising edge k shows as a level-mode request only after edge k+1, not after edge k.
- R2: The mode value has bit 0 from line A up to bit 3 from line D, and a bit is 1 when its pin was high.
- R3: The mode register takes the synchronized pin levels on the first clock edge after reset is released, ignores earlier levels held during reset, and keeps that value while pins change until the next reset.
- R4: While the active-low reset is low, mode, pending and interrupt outputs are all 0.
- R5: A line with trigger bit 1 (falling edge) sets its pending bit on a falling pin and keeps it after the pin returns high until its acknowledge bit is 1 for a cycle.
- R6: If a new falling edge on an edge-triggered line meets its acknowledge in the same cycle, the pending bit stays 1.
- R7: A line with trigger bit 0 (level) shows pending exactly while its synchronized pin is low; acknowledge has no effect on it.
- R8: A mask bit of 1 holds that line's interrupt output at 0; an edge-triggered line still records its pending bit while masked, and the interrupt appears once the mask bit returns to 0.
- R9: Pins held low through reset and after release cause no edge-triggered pending bit.
- R10: The wake output is 1 exactly when the stop input is 1 and synchronized line A is low, regardless of line A's mask; other lines never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| pin_n_i | input | 4 | Raw active-low shared strap/interrupt pins, bit 0 = line A |
| mask_i | input | 4 | Per-line mask, 1 = interrupt output blocked |
| trig_fall_i | input | 4 | Per-line trigger, 1 = falling edge, 0 = level |
| ack_i | input | 4 | Per-line acknowledge for edge-triggered pending bits |
| stop_i | input | 1 | Core is in the stop state |
| mode_o | output | 4 | Operating mode latched at reset release |
| pend_o | output | 4 | Per-line pending request before masking |
| irq_o | output | 4 | Per-line interrupt request after masking |
| wake_o | output | 1 | Request to leave the stop state |

## Verification
All sixteen strap values are driven through a reset release, and each is followed by inverted pins to show the register no longer tracks; a late strap change inside reset separates capture-at-release from capture-while-held. Each line in turn is pulsed in edge mode (sticky until acknowledged, and an edge landing on the acknowledge cycle), in level mode (one-edge-versus-two synchronizer latency, acknowledge ignored) and masked in both modes, which tells a per-line fault from a shared one. Straps held low across reset distinguish a correct start-up gate from a false edge, and the wake tests contrast line A against line B and the stop input against the mask.

// File: rtl/sis_pkg.sv
package sis_pkg;
  // Trigger selection per interrupt line.
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_FALL  = 1'b1
  } trig_e;
endpackage

// File: rtl/sis_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Runs freely through reset so that strap levels are already settled
// when reset is released.
module sis_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] dout_o
);
  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = din_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[CHAIN_W-W-1:0], din_i};
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    chain_q <= chain_d;
  end

  assign dout_o = chain_q[CHAIN_W-1 -: W];
endmodule

// File: rtl/sis_mode_capture.sv
// Freezes the synchronized strap levels on the first edge after reset
// release (R3) and raises the run flag that arms detection (R9).
module sis_mode_capture #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_n_i,
  input  logic [W-1:0] lvl_i,
  output logic         run_o,
  output logic [W-1:0] mode_o
);
  logic         run_q;
  logic         run_d;
  logic [W-1:0] mode_q;
  logic [W-1:0] mode_d;
  logic         cap_en;

  // Capture exactly once: only while run is still low.
  always_comb begin
    cap_en = ~run_q;
    run_d  = 1'b1;
    mode_d = lvl_i;   // R2: bit i = level of line i, 1 = high
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      run_q  <= 1'b0;
      mode_q <= '0;
    end else if (cap_en) begin
      run_q  <= run_d;
      mode_q <= mode_d;
    end
  end

  assign run_o  = run_q;
  assign mode_o = mode_q;
endmodule

// File: rtl/sis_irq_line.sv
// One interrupt line: falling-edge detector with sticky pending flag,
// or transparent level request, followed by the mask gate.
module sis_irq_line
  import sis_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  logic  run_i,
  input  logic  lvl_i,
  input  trig_e trig_i,
  input  logic  mask_i,
  input  logic  ack_i,
  output logic  pend_o,
  output logic  irq_o
);
  logic prev_q;
  logic prev_d;
  logic edge_q;
  logic edge_d;
  logic fall;
  logic lvl_req;

  always_comb begin
    // R9: no detection until the run flag is up
    fall    = run_i & prev_q & ~lvl_i;
    lvl_req = run_i & ~lvl_i;
    prev_d  = lvl_i;
    if (run_i && trig_i == TRIG_FALL) begin
      // R5/R6: a new edge wins over a simultaneous acknowledge
      edge_d = (edge_q & ~ack_i) | fall;
    end else begin
      edge_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      prev_q <= 1'b1;
      edge_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      edge_q <= edge_d;
    end
  end

  // R7: level lines bypass the pending latch
  assign pend_o = (trig_i == TRIG_FALL) ? edge_q : lvl_req;
  // R8: mask only gates the output, never the pending state
  assign irq_o  = pend_o & ~mask_i;
endmodule

// File: rtl/sis_strap_irq_top.sv
module sis_strap_irq_top
  import sis_pkg::*;
#(
  parameter int unsigned NUM_LINES   = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WAKE_LINE   = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_n_i,
  input  logic [NUM_LINES-1:0] pin_n_i,
  input  logic [NUM_LINES-1:0] mask_i,
  input  logic [NUM_LINES-1:0] trig_fall_i,
  input  logic [NUM_LINES-1:0] ack_i,
  input  logic                 stop_i,
  output logic [NUM_LINES-1:0] mode_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic [NUM_LINES-1:0] irq_o,
  output logic                 wake_o
);
  logic [NUM_LINES-1:0] lvl;
  logic                 run;

  // R1: every pin is synchronized before use
  sis_sync #(
    .W      (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) sync_i (
    .clk_i  (clk_i),
    .din_i  (pin_n_i),
    .dout_o (lvl)
  );

  sis_mode_capture #(
    .W (NUM_LINES)
  ) cap_i (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .lvl_i   (lvl),
    .run_o   (run),
    .mode_o  (mode_o)
  );

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      sis_irq_line line_i (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .run_i   (run),
        .lvl_i   (lvl[i]),
        .trig_i  (trig_e'(trig_fall_i[i])),
        .mask_i  (mask_i[i]),
        .ack_i   (ack_i[i]),
        .pend_o  (pend_o[i]),
        .irq_o   (irq_o[i])
      );
    end
  endgenerate

  // R10: wake ignores the mask and depends only on stop and the level
  assign wake_o = stop_i & ~lvl[WAKE_LINE];
endmodule

// File: rtl/sis_strap_irq_chk.sv
module sis_strap_irq_chk #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input logic         clk_i,
  input logic         rst_n_i,
  input logic         run_i,
  input logic [N-1:0] pin_n_i,
  input logic [N-1:0] mask_i,
  input logic [N-1:0] trig_fall_i,
  input logic [N-1:0] ack_i,
  input logic         stop_i,
  input logic [N-1:0] mode_o,
  input logic [N-1:0] pend_o,
  input logic [N-1:0] irq_o,
  input logic         wake_o
);
  p_mode_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (run_i && $past(run_i)) |-> $stable(mode_o));

  p_quiet_start_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !run_i |=> ((pend_o & trig_fall_i) == '0));

  p_wake_needs_stop_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !stop_i |-> !wake_o);

  generate
    for (genvar i = 0; i < N; i++) begin : g_chk
      p_edge_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (trig_fall_i[i] && pend_o[i] && !ack_i[i]) |=> (!trig_fall_i[i] || pend_o[i]));

      p_unmask_reveal_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        ($fell(mask_i[i]) && pend_o[i]) |-> irq_o[i]);

      if (STAGES == 2) begin : g_lat
        p_level_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
          (run_i && $past(run_i) && !trig_fall_i[i]) |-> (pend_o[i] == !$past(pin_n_i[i], 2)));
      end
    end
  endgenerate
endmodule

bind sis_strap_irq_top sis_strap_irq_chk #(
  .N      (NUM_LINES),
  .STAGES (SYNC_STAGES)
) chk_i (
  .clk_i       (clk_i),
  .rst_n_i     (rst_n_i),
  .run_i       (run),
  .pin_n_i     (pin_n_i),
  .mask_i      (mask_i),
  .trig_fall_i (trig_fall_i),
  .ack_i       (ack_i),
  .stop_i      (stop_i),
  .mode_o      (mode_o),
  .pend_o      (pend_o),
  .irq_o       (irq_o),
  .wake_o      (wake_o)
);

// File: tb/sis_strap_irq_top_tb_top.sv
module sis_strap_irq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] pin_n;
  logic [N-1:0] mask;
  logic [N-1:0] trig;
  logic [N-1:0] ack;
  logic         stop;
  logic [N-1:0] mode;
  logic [N-1:0] pend;
  logic [N-1:0] irq;
  logic         wake;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sis_strap_irq_top dut_i (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .pin_n_i     (pin_n),
    .mask_i      (mask),
    .trig_fall_i (trig),
    .ack_i       (ack),
    .stop_i      (stop),
    .mode_o      (mode),
    .pend_o      (pend),
    .irq_o       (irq),
    .wake_o      (wake)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [N-1:0] strap);
    @(negedge clk);
    rst_n = 1'b0;
    pin_n = strap;
    tick(4);
    rst_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    pin_n = '1;
    mask  = '0;
    trig  = '1;
    ack   = '0;
    stop  = 1'b0;
    tick(4);
    // R4: cleared state while reset is low
    chk("R4 mode", int'(mode), 0);
    chk("R4 pend", int'(pend), 0);
    chk("R4 irq", int'(irq), 0);

    // R2/R3: every strap value, then pins flipped afterwards
    for (int m = 0; m < 16; m++) begin
      do_reset(N'(m));
      chk("R2 mode capture", int'(mode), m);
      pin_n = ~N'(m);
      tick(4);
      chk("R3 mode held", int'(mode), m);
      @(negedge clk);
      rst_n = 1'b0;
      tick(1);
      chk("R4 mode cleared in reset", int'(mode), 0);
      rst_n = 1'b1;
    end

    // R3: only the level at release counts
    @(negedge clk);
    rst_n = 1'b0;
    pin_n = 4'h5;
    tick(4);
    pin_n = 4'hA;
    tick(4);
    rst_n = 1'b1;
    tick(3);
    chk("R3 late strap", int'(mode), 'hA);

    // R9: straps held low across reset in edge mode
    trig = '1;
    do_reset(4'h0);
    tick(5);
    chk("R9 no false edge", int'(pend), 0);
    pin_n = '1;
    tick(4);
    chk("R9 rising ignored", int'(pend), 0);

    // Edge mode per line
    for (int i = 0; i < N; i++) begin
      trig = '1; mask = '0;
      pin_n[i] = 1'b0;
      tick(4);
      chk("R5 edge sets pend", int'(pend), 1 << i);
      chk("R5 edge irq", int'(irq), 1 << i);
      pin_n[i] = 1'b1;
      tick(4);
      chk("R5 pend sticky", int'(pend), 1 << i);
      ack[i] = 1'b1;
      tick(1);
      ack = '0;
      tick(1);
      chk("R5 ack clears", int'(pend), 0);
      // R6: edge and acknowledge in the same cycle
      pin_n[i] = 1'b0;
      tick(4);
      pin_n[i] = 1'b1;
      tick(4);
      pin_n[i] = 1'b0;
      tick(2);
      ack[i] = 1'b1;
      tick(1);
      ack = '0;
      tick(1);
      chk("R6 edge beats ack", int'(pend), 1 << i);
      pin_n[i] = 1'b1;
      tick(3);
      ack[i] = 1'b1;
      tick(1);
      ack = '0;
      tick(1);
      chk("R6 later ack clears", int'(pend), 0);
    end

    // Level mode per line
    for (int i = 0; i < N; i++) begin
      trig = '0; mask = '0;
      pin_n[i] = 1'b0;
      tick(1);
      chk("R1 one edge not enough", int'(pend), 0);
      tick(1);
      chk("R1 two edges", int'(pend), 1 << i);
      ack = '1;
      tick(2);
      chk("R7 ack ignored", int'(pend), 1 << i);
      ack = '0;
      pin_n[i] = 1'b1;
      tick(1);
      chk("R7 still low in sync", int'(pend), 1 << i);
      tick(1);
      chk("R7 follows release", int'(pend), 0);
    end

    // Masking per line
    for (int i = 0; i < N; i++) begin
      trig = '1; mask = '1;
      pin_n[i] = 1'b0;
      tick(4);
      chk("R8 masked edge pend", int'(pend), 1 << i);
      chk("R8 masked irq low", int'(irq), 0);
      mask = '0;
      tick(1);
      chk("R8 unmask reveals", int'(irq), 1 << i);
      pin_n[i] = 1'b1;
      ack[i] = 1'b1;
      tick(1);
      ack = '0;
      tick(3);
      trig = '0; mask = '1;
      pin_n[i] = 1'b0;
      tick(4);
      chk("R8 masked level pend", int'(pend), 1 << i);
      chk("R8 masked level irq", int'(irq), 0);
      pin_n[i] = 1'b1;
      mask = '0;
      tick(4);
    end

    // Wake
    trig = '1; mask = '1;
    stop = 1'b1;
    tick(3);
    chk("R10 idle no wake", int'(wake), 0);
    pin_n[0] = 1'b0;
    tick(3);
    chk("R10 line A wakes despite mask", int'(wake), 1);
    pin_n[0] = 1'b1;
    pin_n[1] = 1'b0;
    tick(3);
    chk("R10 line B no wake", int'(wake), 0);
    pin_n[1] = 1'b1;
    pin_n[0] = 1'b0;
    stop = 1'b0;
    tick(3);
    chk("R10 no stop no wake", int'(wake), 0);
    pin_n = '1;
    tick(3);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule